// File: doc/BRIEF.md
# Chained Descriptor DMA Engine

This block moves the data of a card-host transfer between the data path and system memory, one 32-bit word per granted bus cycle. Software can hand it a single contiguous buffer. It can also hand it a chain of buffers described by three-word records held in memory. For a chain, software loads the first record straight into the registers and sets the start and chain bits. When a buffer runs out, the engine reads the next record itself and keeps going until a record says it is the final one.

A record holds three words, in this fixed order: the link word, the buffer address and the buffer byte count. The link word gives the byte offset of the next record, measured from the record base register. It also carries three flags. One says another record follows. One says the byte count must be reloaded on the next fetch. One asks for a pulse when this buffer completes. Checks made at run time halt the engine on a misaligned address, or on a non-final count that is not a whole number of bursts.

Top module: `ll_dma`

## Requirements
- R1: After reset, status (register 5: bit0 done, bit1 error, bit2 busy) reads 0 and `mem_req` is low.
- R2: Writing control (register 0) with bit0 set and bit1 clear moves `blk_bytes` bytes. It issues ceil(`blk_bytes`/4) word accesses at consecutive addresses from the address register (register 3), with `mem_we` equal to control bit2. It fetches nothing and then sets done.
- R3: With control bit1 set, when a buffer is used up and its link word bit31 is set, the engine reads the next record at base (register 1) plus link bits [28:0]. It reads the link word at +0, the address at +4 and the count at +8, then transfers that buffer.
- R4: If the finishing buffer's link word bit30 is clear, the fetch reads only +0 and +4, and the previous byte count is reused.
- R5: A buffer whose link bit31 is clear is the last one. Once its count reaches zero, done is set and busy drops.
- R6: A buffer address with bits [1:0] nonzero, either at start or in a fetched record, sets a sticky error flag and issues no further requests. Done stays clear.
- R7: A buffer whose link bit31 is set and whose byte count is not a multiple of BURST_BYTES raises the error of R6.
- R8: When a buffer ends and its link bit29 is set, `buf_ack` pulses high for one cycle.
- R9: Writing 0 to control during a transfer lets the current buffer finish. The engine then stops, with no record fetch and without setting done.
- R10: While `mem_req` is high and `mem_gnt` is low, `mem_addr` holds and the request stays up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 control, 1 record base, 2 link, 3 address, 4 count, 5 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| blk_bytes | input | LEN_W | Transfer length used in single-buffer mode |
| wr_data | input | 32 | Data written to memory in write direction |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access accepted this cycle |
| mem_rdata | input | 32 | Read data, valid the cycle after a granted read |
| buf_ack | output | 1 | One-cycle pulse for a completed buffer whose acknowledge flag is set |

## Verification
On every cycle the assertions check four things: a request never carries a misaligned address, a stalled request holds its address, a halted engine issues no requests, and done never coexists with busy. They also check that the acknowledge pulse lasts a single cycle. Only the scenarios can show the order and addresses of record fetches, the skipped count fetch, the reused count, the early stop, and where an error interrupts a chain. The bench sweeps chain length, the reload flag, acknowledge masks and grant stalls, and compares the logged bus traffic against addresses it computes itself.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_MOVE, ST_FREQ, ST_FWAIT} walk_st_t;

  // link word fields (decoded by the walker on every fetch)
  localparam int LNK_CONT   = 31;
  localparam int LNK_RELOAD = 30;
  localparam int LNK_ACK    = 29;
  localparam int OFF_W      = 29;

  // register indices
  localparam logic [2:0] RI_CTRL = 3'd0;
  localparam logic [2:0] RI_BASE = 3'd1;
  localparam logic [2:0] RI_LINK = 3'd2;
  localparam logic [2:0] RI_ADDR = 3'd3;
  localparam logic [2:0] RI_SIZE = 3'd4;
  localparam logic [2:0] RI_STAT = 3'd5;
endpackage

// File: rtl/ll_dma_regs.sv
module ll_dma_regs
  import lldma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             busy,
  input  logic             done,
  input  logic             err,
  output logic [AW-1:0]    cfg_base,
  output logic [31:0]      cfg_link,
  output logic [AW-1:0]    cfg_addr,
  output logic [LEN_W-1:0] cfg_size,
  output logic             chain,
  output logic             dir,
  output logic             start,
  output logic             stop
);
  logic [2:0] ctrl_q;

  assign chain = ctrl_q[1];
  assign dir   = ctrl_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      cfg_base  <= '0;
      cfg_link  <= '0;
      cfg_addr  <= '0;
      cfg_size  <= '0;
      start     <= 1'b0;
      stop      <= 1'b0;
      reg_rdata <= '0;
    end else begin
      start <= 1'b0;
      stop  <= 1'b0;
      if (reg_we) begin
        case (reg_addr)
          RI_CTRL: begin
            ctrl_q <= reg_wdata[2:0];
            if (reg_wdata == 32'd0) stop <= 1'b1;
            else if (reg_wdata[0] && !busy) start <= 1'b1;
          end
          RI_BASE: if (!busy) cfg_base <= reg_wdata[AW-1:0];
          RI_LINK: if (!busy) cfg_link <= reg_wdata;
          RI_ADDR: if (!busy) cfg_addr <= reg_wdata[AW-1:0];
          RI_SIZE: if (!busy) cfg_size <= reg_wdata[LEN_W-1:0];
          default: ;
        endcase
      end
      case (reg_addr)
        RI_CTRL: reg_rdata <= {29'd0, ctrl_q};
        RI_BASE: reg_rdata <= 32'(cfg_base);
        RI_LINK: reg_rdata <= cfg_link;
        RI_ADDR: reg_rdata <= 32'(cfg_addr);
        RI_SIZE: reg_rdata <= 32'(cfg_size);
        RI_STAT: reg_rdata <= {29'd0, busy, err, done};
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ll_dma_walker.sv
module ll_dma_walker
  import lldma_pkg::*;
#(
  parameter int AW          = 32,
  parameter int LEN_W       = 16,
  parameter int BURST_BYTES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             stop,
  input  logic             chain,
  input  logic             dir,
  input  logic [AW-1:0]    cfg_base,
  input  logic [31:0]      cfg_link,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [LEN_W-1:0] cfg_size,
  input  logic [LEN_W-1:0] blk_bytes,
  input  logic             mem_gnt,
  input  logic [31:0]      mem_rdata,
  input  logic [31:0]      wr_data,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  output logic             buf_ack,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int BW = $clog2(BURST_BYTES);

  walk_st_t         st;
  logic [31:0]      cur_link, nlink;
  logic [AW-1:0]    cur_addr, fetch_base;
  logic [LEN_W-1:0] cnt, len_keep, fin_sz, dec;
  logic [1:0]       fidx;
  logic             stop_pend, dir_q;

  assign fin_sz    = (fidx == 2'd2) ? mem_rdata[LEN_W-1:0] : len_keep;
  assign dec       = (cnt < LEN_W'(4)) ? cnt : LEN_W'(4);
  assign busy      = (st != ST_IDLE);
  assign mem_req   = (st == ST_MOVE && cnt != '0) || (st == ST_FREQ);
  assign mem_we    = (st == ST_MOVE) && dir_q;
  assign mem_addr  = (st == ST_FREQ) ? fetch_base + AW'({fidx, 2'b00}) : cur_addr;
  assign mem_wdata = wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur_link   <= '0;
      nlink      <= '0;
      cur_addr   <= '0;
      fetch_base <= '0;
      cnt        <= '0;
      len_keep   <= '0;
      fidx       <= '0;
      stop_pend  <= 1'b0;
      dir_q      <= 1'b0;
      buf_ack    <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      buf_ack <= 1'b0;
      if (stop && st != ST_IDLE) stop_pend <= 1'b1;
      case (st)
        ST_IDLE: if (start) begin
          done      <= 1'b0;
          err       <= 1'b0;
          stop_pend <= 1'b0;
          dir_q     <= dir;
          cur_addr  <= cfg_addr;
          if (chain) begin
            cur_link <= cfg_link;
            cnt      <= cfg_size;
            len_keep <= cfg_size;
          end else begin
            cur_link <= '0;
            cnt      <= blk_bytes;
            len_keep <= blk_bytes;
          end
          if (cfg_addr[1:0] != 2'b00 ||
              (chain && cfg_link[LNK_CONT] && cfg_size[BW-1:0] != '0)) err <= 1'b1;
          else st <= ST_MOVE;
        end
        ST_MOVE: begin
          if (cnt == '0) begin
            buf_ack    <= cur_link[LNK_ACK];
            fidx       <= 2'd0;
            fetch_base <= cfg_base + AW'(cur_link[OFF_W-1:0]);
            if (stop_pend) st <= ST_IDLE;
            else if (cur_link[LNK_CONT]) st <= ST_FREQ;
            else begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end
          end else if (mem_gnt) begin
            cur_addr <= cur_addr + AW'(4);
            cnt      <= cnt - dec;
          end
        end
        ST_FREQ: if (mem_gnt) st <= ST_FWAIT;
        ST_FWAIT: begin
          if (fidx == 2'd0) begin
            nlink <= mem_rdata;
            fidx  <= 2'd1;
            st    <= ST_FREQ;
          end else if (fidx == 2'd1 && mem_rdata[1:0] != 2'b00) begin
            err <= 1'b1;
            st  <= ST_IDLE;
          end else if (fidx == 2'd1 && cur_link[LNK_RELOAD]) begin
            cur_addr <= mem_rdata[AW-1:0];
            fidx     <= 2'd2;
            st       <= ST_FREQ;
          end else begin
            if (fidx == 2'd1) cur_addr <= mem_rdata[AW-1:0];
            if (nlink[LNK_CONT] && fin_sz[BW-1:0] != '0) begin
              err <= 1'b1;
              st  <= ST_IDLE;
            end else begin
              cnt      <= fin_sz;
              len_keep <= fin_sz;
              cur_link <= nlink;
              st       <= ST_MOVE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst) err |-> !mem_req);
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst) buf_ack |=> !buf_ack);
endmodule

// File: rtl/ll_dma.sv
module ll_dma #(
  parameter int AW          = 32,
  parameter int LEN_W       = 16,
  parameter int BURST_BYTES = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [LEN_W-1:0] blk_bytes,
  input  logic [31:0]      wr_data,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic             mem_gnt,
  input  logic [31:0]      mem_rdata,
  output logic             buf_ack
);
  logic [AW-1:0]    cfg_base, cfg_addr;
  logic [31:0]      cfg_link;
  logic [LEN_W-1:0] cfg_size;
  logic             chain, dir, start, stop, busy, done, err;

  ll_dma_regs #(.AW(AW), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done(done), .err(err),
    .cfg_base(cfg_base), .cfg_link(cfg_link), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .chain(chain), .dir(dir), .start(start), .stop(stop)
  );

  ll_dma_walker #(.AW(AW), .LEN_W(LEN_W), .BURST_BYTES(BURST_BYTES)) u_walk (
    .clk(clk), .rst(rst), .start(start), .stop(stop), .chain(chain), .dir(dir),
    .cfg_base(cfg_base), .cfg_link(cfg_link), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .blk_bytes(blk_bytes),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .wr_data(wr_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .buf_ack(buf_ack), .busy(busy), .done(done), .err(err)
  );
endmodule

// File: tb/ll_dma_tb.sv
`timescale 1ns/1ps
module ll_dma_tb;
  localparam int AW = 32, LEN_W = 16, BURST = 32;
  localparam logic [31:0] DB = 32'h40;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst, reg_we, mem_req, mem_we, mem_gnt, buf_ack, stall_en;
  logic [2:0]       reg_addr;
  logic [31:0]      reg_wdata, reg_rdata, wr_data, mem_wdata, mem_rdata, st_v;
  logic [LEN_W-1:0] blk_bytes;
  logic [AW-1:0]    mem_addr;
  logic [7:0]       lfsr;
  logic [31:0]      mem [0:63];
  logic [31:0]      acc_addr [0:2047];
  logic             acc_we [0:2047];
  logic [31:0]      exp_a [0:511];
  logic             exp_w [0:511];
  int nacc, nack, ne, total, bad;

  ll_dma #(.AW(AW), .LEN_W(LEN_W), .BURST_BYTES(BURST)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .blk_bytes(blk_bytes), .wr_data(wr_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .buf_ack(buf_ack)
  );

  // memory model: grant pattern, one-cycle read latency, access log
  always @(posedge clk) begin
    if (rst) begin
      mem_gnt <= 1'b1; lfsr <= 8'hA5; nacc <= 0; nack <= 0; mem_rdata <= '0;
    end else begin
      lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_gnt <= stall_en ? lfsr[0] : 1'b1;
      if (mem_req && mem_gnt && nacc < 2048) begin
        acc_addr[nacc] <= mem_addr;
        acc_we[nacc]   <= mem_we;
        nacc           <= nacc + 1;
        mem_rdata      <= mem[mem_addr[7:2]];
      end
      if (buf_ack) nack <= nack + 1;
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] a, input logic [31:0] e);
    total++;
    if (a !== e) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, a, e);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = idx; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx);
    @(negedge clk); reg_addr = idx;
    @(negedge clk); st_v = reg_rdata;
  endtask

  task automatic push(input logic [31:0] a, input logic w);
    exp_a[ne] = a; exp_w[ne] = w; ne++;
  endtask

  task automatic wait_idle();
    repeat (4) @(negedge clk);
    for (int k = 0; k < 4000; k++) begin
      rd(3'd5);
      if (!st_v[2]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_check(input string rq, input int base, input logic e_done, input logic e_err);
    int mis;
    mis = -1;
    chk(rq, "access count", 32'(nacc - base), 32'(ne));
    for (int k = 0; k < ne && k < nacc - base; k++)
      if (mis < 0 && (acc_addr[base+k] !== exp_a[k] || acc_we[base+k] !== exp_w[k])) mis = k;
    if (mis >= 0) begin
      chk(rq, "access addr", acc_addr[base+mis], exp_a[mis]);
      chk(rq, "access we", 32'(acc_we[base+mis]), 32'(exp_w[mis]));
    end else chk(rq, "access sequence", 32'd0, 32'd0);
    chk(rq, "done", 32'(st_v[0]), 32'(e_done));
    chk(rq, "error", 32'(st_v[1]), 32'(e_err));
  endtask

  // R2 single buffer sweep
  task automatic run_single(input int len, input logic d);
    int base;
    base = nacc; ne = 0;
    for (int k = 0; k < (len + 3) / 4; k++) push(32'h2000 + 32'(4 * k), d);
    blk_bytes = LEN_W'(len);
    wr(3'd3, 32'h2000);
    wr(3'd0, {29'd0, d, 2'b01});
    wait_idle();
    finish_check("R2", base, 1'b1, 1'b0);
  endtask

  // R3 R4 R5 R8 R10 chains
  task automatic run_chain(input int nd, input logic rl, input logic stl, input logic [2:0] ackm);
    int base, ab, eacks;
    logic [31:0] sz [0:2];
    logic [31:0] lk [0:2];
    logic [31:0] eff;
    stall_en = stl;
    base = nacc; ab = nack; ne = 0; eacks = 0;
    for (int i = 0; i < nd; i++) begin
      sz[i] = (i == nd - 1 && nd == 3) ? 32'd13 : 32'(32 * (i + 1));
      lk[i] = 32'((i + 1) * 12) | ((i < nd - 1) ? 32'h8000_0000 : 32'h0)
            | (rl ? 32'h4000_0000 : 32'h0) | (ackm[i] ? 32'h2000_0000 : 32'h0);
      mem[16 + 3*i] = lk[i];
      mem[17 + 3*i] = 32'h1000 + 32'(i * 32'h100);
      mem[18 + 3*i] = sz[i];
      if (ackm[i]) eacks++;
    end
    for (int i = 0; i < nd; i++) begin
      eff = (i == 0 || rl) ? sz[i] : sz[0];
      for (int k = 0; k < (int'(eff) + 3) / 4; k++) push(32'h1000 + 32'(i * 32'h100) + 32'(4 * k), 1'b0);
      if (i < nd - 1) begin
        push(DB + 32'((i + 1) * 12), 1'b0);
        push(DB + 32'((i + 1) * 12) + 32'd4, 1'b0);
        if (rl) push(DB + 32'((i + 1) * 12) + 32'd8, 1'b0);
      end
    end
    wr(3'd1, DB); wr(3'd2, lk[0]); wr(3'd3, 32'h1000); wr(3'd4, sz[0]);
    wr(3'd0, 32'd3);
    wait_idle();
    finish_check(rl ? (stl ? "R10" : "R3") : "R4", base, 1'b1, 1'b0);
    chk("R5", "busy after last", 32'(st_v[2]), 32'd0);
    chk("R8", "ack pulses", 32'(nack - ab), 32'(eacks));
    stall_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    total = 0; bad = 0; stall_en = 1'b0;
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; blk_bytes = '0; wr_data = 32'h5A5A_0001;
    for (int i = 0; i < 64; i++) mem[i] = 32'(i);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1
    rd(3'd5);
    chk("R1", "status", st_v, 32'd0);
    chk("R1", "mem_req", 32'(mem_req), 32'd0);

    foreach (exp_a[i]) begin end
    run_single(0, 1'b0);
    run_single(1, 1'b1);
    run_single(4, 1'b0);
    run_single(7, 1'b1);
    run_single(16, 1'b0);
    run_single(33, 1'b1);

    for (int nd = 1; nd <= 3; nd++)
      for (int rl = 0; rl < 2; rl++)
        for (int s = 0; s < 2; s++)
          run_chain(nd, rl[0], s[0], 3'(nd + rl + s));

    // R6 misaligned start address
    base = nacc; ne = 0; blk_bytes = 16;
    wr(3'd3, 32'h2002); wr(3'd0, 32'd1); wait_idle();
    finish_check("R6", base, 1'b0, 1'b1);

    // R7 non-final count not a burst multiple at start
    base = nacc; ne = 0;
    wr(3'd1, DB); wr(3'd2, 32'h8000_000C); wr(3'd3, 32'h1000); wr(3'd4, 32'd20);
    wr(3'd0, 32'd3); wait_idle();
    finish_check("R7", base, 1'b0, 1'b1);

    // R6 misaligned address in fetched record
    mem[19] = 32'h0; mem[20] = 32'h1102; mem[21] = 32'd8;
    base = nacc; ne = 0;
    for (int k = 0; k < 8; k++) push(32'h1000 + 32'(4 * k), 1'b0);
    push(DB + 32'd12, 1'b0); push(DB + 32'd16, 1'b0);
    wr(3'd2, 32'hC000_000C); wr(3'd3, 32'h1000); wr(3'd4, 32'd32);
    wr(3'd0, 32'd3); wait_idle();
    finish_check("R6", base, 1'b0, 1'b1);

    // R7 fetched record continues with a bad count
    mem[19] = 32'hC000_0018; mem[20] = 32'h1100; mem[21] = 32'd40;
    base = nacc; ne = 0;
    for (int k = 0; k < 8; k++) push(32'h1000 + 32'(4 * k), 1'b0);
    push(DB + 32'd12, 1'b0); push(DB + 32'd16, 1'b0); push(DB + 32'd20, 1'b0);
    wr(3'd0, 32'd3); wait_idle();
    finish_check("R7", base, 1'b0, 1'b1);

    // R9 stop request during first buffer of a chain
    mem[19] = 32'h0; mem[20] = 32'h1100; mem[21] = 32'd8;
    base = nacc; ne = 0;
    for (int k = 0; k < 128; k++) push(32'h3000 + 32'(4 * k), 1'b0);
    wr(3'd2, 32'h8000_000C); wr(3'd3, 32'h3000); wr(3'd4, 32'd512);
    wr(3'd0, 32'd3);
    repeat (10) @(negedge clk);
    wr(3'd0, 32'd0);
    wait_idle();
    finish_check("R9", base, 1'b0, 1'b0);
    chk("R9", "busy", 32'(st_v[2]), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule